// File: doc/BRIEF.md
# Masked Multi-Slot Bus Address Recognizer

This block sits behind the synchronizers of a two-wire serial bus target. After each START strobe it collects the next eight data bits, most significant bit first, on rising SCL. It treats the top seven bits as an address and the last bit as the transfer direction. The address is compared against a set of own-address slots. Each slot carries a 7-bit address, a per-bit don't-care mask and a general-call enable. If a slot accepts the address, the block latches which slot won, whether the acceptance came through the general-call path, and the direction bit. It then pulls SDA low for the acknowledge clock.

While the device is acting as a bus controller (`master_i` high), the slots are disregarded and no address is ever accepted. A STOP, or a START arriving part-way through, abandons the current recognition. The latched result stays valid until the next START or STOP, so the data-phase logic can read it at any time during the transfer.

Top module: `i2c_addr_match`

## Requirements
- R1: While reset is held, and after it is released, `match_o`, `match_slot_o`, `gcall_o`, `rw_o` and `sda_pull_o` are all 0.
- R2: After a START, the block shifts `sda_i` in, MSB first, on each cycle where `scl_i` is sampled high after being sampled low. The eighth bit completes the byte. Byte bits [7:1] form the address, and byte bit 0 is reported on `rw_o` (1 = read).
- R3: Slot k of `slot_cfg_i` holds its address in bits [8k+7:8k+1] and its general-call enable in bit 8k. Slot k of `slot_mask_i` occupies bits [7k+6:7k]. A mask bit of 1 makes that address bit don't-care, and a mask bit of 0 requires equality.
- R4: A received address of 0 is accepted by any slot whose general-call enable is 1. When that slot wins, `gcall_o` is 1.
- R5: An address of 0 is rejected unless some slot's general-call enable is set or some slot matches it through its address and mask. A rejected byte leaves `match_o` and `sda_pull_o` at 0.
- R6: When several slots accept the address, `match_slot_o` reports the lowest-numbered one. `gcall_o` reflects that slot only.
- R7: If `master_i` is 1 on the cycle the eighth bit is taken, no match is reported and no acknowledge is driven.
- R8: On a match, `sda_pull_o` rises on the cycle after the first low sample of SCL that follows the eighth bit. It stays high through the ninth SCL high phase. It falls on the cycle after the following low sample.
- R9: `stop_i` clears all outputs on the next cycle and returns the block to idle. `start_i` does the same and restarts bit collection. If both arrive in the same cycle, the STOP behaviour applies.
- R10: A reported match, with its slot, general-call flag and direction bit, stays unchanged until the next `start_i` or `stop_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| start_i | input | 1 | One-cycle START (or repeated START) strobe |
| stop_i | input | 1 | One-cycle STOP strobe |
| master_i | input | 1 | Device is operating as bus controller |
| slot_cfg_i | input | 32 | Per slot: address [7:1], general-call enable [0] |
| slot_mask_i | input | 28 | Per slot: 7-bit don't-care mask |
| match_o | output | 1 | Address accepted in this transfer |
| match_slot_o | output | 2 | Index of the winning slot |
| gcall_o | output | 1 | Acceptance came through the general-call path |
| rw_o | output | 1 | Received direction bit |
| sda_pull_o | output | 1 | Drive SDA low (acknowledge) |

## Verification
The bench builds the block with its default four slots of seven address bits. With that many slots, the priority cases become reachable: two slots accepting the same address through different masks, and the general-call enable set on a higher slot while a lower slot also matches. Mid-byte STOP, mid-byte repeated START and coincident START/STOP are driven at the ports. A behavioural model tracks the expected outputs on every cycle of these cases. Controller mode is raised only across a complete address byte, so the suppression is seen on both the match and the acknowledge.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ARM,
    ST_DRIVE,
    ST_HOLD
  } am_state_e;
endpackage

// File: rtl/i2c_am_edge.sv
module i2c_am_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q;

  // bus idles high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_q <= 1'b1;
    else         scl_q <= scl_i;
  end

  assign rise_o = scl_i & ~scl_q;
  assign fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift #(
  parameter int BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            shift_en_i,
  input  logic            sda_i,
  output logic [BITS-1:0] byte_nxt_o,
  output logic            last_o
);
  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;

  logic [BITS-1:0] sh_q;
  logic [CW-1:0]   cnt_q;

  assign byte_nxt_o = {sh_q[BITS-2:0], sda_i};
  assign last_o     = shift_en_i && (cnt_q == CW'(BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_en_i) begin
      sh_q  <= byte_nxt_o;
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_am_compare.sv
module i2c_am_compare #(
  parameter int NSLOT = 4,
  parameter int AW    = 7,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [AW-1:0]           rx_addr_i,
  input  logic [NSLOT*(AW+1)-1:0] slot_cfg_i,
  input  logic [NSLOT*AW-1:0]     slot_mask_i,
  output logic                    hit_o,
  output logic [SW-1:0]           slot_o,
  output logic                    gcall_o
);
  logic [NSLOT-1:0] hit_vec;
  logic [NSLOT-1:0] gc_vec;
  logic             rx_zero;

  assign rx_zero = (rx_addr_i == '0);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [AW-1:0] own;
    logic [AW-1:0] msk;
    logic          norm;
    assign own        = slot_cfg_i[g*(AW+1)+1 +: AW];
    assign msk        = slot_mask_i[g*AW +: AW];
    assign norm       = &(~(rx_addr_i ^ own) | msk);
    assign gc_vec[g]  = slot_cfg_i[g*(AW+1)] & rx_zero;
    assign hit_vec[g] = norm | gc_vec[g];
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit_o   = |hit_vec;
    slot_o  = '0;
    gcall_o = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        slot_o  = SW'(i);
        gcall_o = gc_vec[i];
      end
    end
    p_gcall_zero_r4: assert (!gcall_o || rx_zero)
      else $error("general call flagged on nonzero address");
  end
endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
  import i2c_am_pkg::*;
#(
  parameter int SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          master_i,
  input  logic          last_i,
  input  logic          hit_i,
  input  logic [SW-1:0] slot_i,
  input  logic          gcall_i,
  input  logic          rw_i,
  output am_state_e     state_o,
  output logic          match_o,
  output logic [SW-1:0] match_slot_o,
  output logic          gcall_o,
  output logic          rw_o,
  output logic          sda_pull_o
);
  am_state_e state_q;

  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      match_o      <= 1'b0;
      match_slot_o <= '0;
      gcall_o      <= 1'b0;
      rw_o         <= 1'b0;
      sda_pull_o   <= 1'b0;
    end else if (stop_i || start_i) begin
      state_q      <= stop_i ? ST_IDLE : ST_SHIFT;
      match_o      <= 1'b0;
      match_slot_o <= '0;
      gcall_o      <= 1'b0;
      rw_o         <= 1'b0;
      sda_pull_o   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SHIFT: if (last_i) begin
          if (hit_i && !master_i) begin
            match_o      <= 1'b1;
            match_slot_o <= slot_i;
            gcall_o      <= gcall_i;
            rw_o         <= rw_i;
            state_q      <= ST_ARM;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_ARM: if (fall_i) begin
          sda_pull_o <= 1'b1;
          state_q    <= ST_DRIVE;
        end
        ST_DRIVE: if (rise_i) state_q <= ST_HOLD;
        ST_HOLD: if (fall_i) begin
          sda_pull_o <= 1'b0;
          state_q    <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  p_pull_needs_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> match_o);
  p_pull_on_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> $past(fall_i));
  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i || start_i) |=> (!match_o && !sda_pull_o));
  p_master_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> !$past(master_i));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !start_i && !stop_i) |=> (match_o && $stable(match_slot_o)
      && $stable(gcall_o) && $stable(rw_o)));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int AW    = 7,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int BITS = AW + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic                    start_i,
  input  logic                    stop_i,
  input  logic                    master_i,
  input  logic [NSLOT*(AW+1)-1:0] slot_cfg_i,
  input  logic [NSLOT*AW-1:0]     slot_mask_i,
  output logic                    match_o,
  output logic [SW-1:0]           match_slot_o,
  output logic                    gcall_o,
  output logic                    rw_o,
  output logic                    sda_pull_o
);
  logic            rise, fall, last, hit, cmp_gc;
  logic [SW-1:0]   cmp_slot;
  logic [BITS-1:0] byte_nxt;
  am_state_e       state;

  i2c_am_edge i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  i2c_am_shift #(.BITS(BITS)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_i | stop_i),
    .shift_en_i(rise && (state == ST_SHIFT)),
    .sda_i     (sda_i),
    .byte_nxt_o(byte_nxt),
    .last_o    (last)
  );

  i2c_am_compare #(.NSLOT(NSLOT), .AW(AW)) i_cmp (
    .rx_addr_i  (byte_nxt[BITS-1:1]),
    .slot_cfg_i (slot_cfg_i),
    .slot_mask_i(slot_mask_i),
    .hit_o      (hit),
    .slot_o     (cmp_slot),
    .gcall_o    (cmp_gc)
  );

  i2c_am_ctrl #(.SW(SW)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .fall_i      (fall),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .master_i    (master_i),
    .last_i      (last),
    .hit_i       (hit),
    .slot_i      (cmp_slot),
    .gcall_i     (cmp_gc),
    .rw_i        (byte_nxt[0]),
    .state_o     (state),
    .match_o     (match_o),
    .match_slot_o(match_slot_o),
    .gcall_o     (gcall_o),
    .rw_o        (rw_o),
    .sda_pull_o  (sda_pull_o)
  );

  p_no_pull_in_master_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && !match_o) |-> !sda_pull_o);
endmodule

// File: tb/test_i2c_addr_match.sv
`timescale 1ns/1ps
module test_i2c_addr_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, start = 1'b0, stop = 1'b0, master = 1'b0;
  logic [31:0] cfg_v;
  logic [27:0] mask_v;
  logic [7:0] cfg_a [4];
  logic [6:0] cfg_m [4];
  logic match, gcall, rw, pull;
  logic [1:0] slot;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      cfg_v[k*8 +: 8]  = cfg_a[k];
      mask_v[k*7 +: 7] = cfg_m[k];
    end
  end

  i2c_addr_match i_i2c_addr_match (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .start_i(start), .stop_i(stop), .master_i(master),
    .slot_cfg_i(cfg_v), .slot_mask_i(mask_v),
    .match_o(match), .match_slot_o(slot), .gcall_o(gcall),
    .rw_o(rw), .sda_pull_o(pull)
  );

  // behavioural reference
  int   m_phase, m_cnt, m_byte;
  logic m_prev;
  logic e_match, e_gc, e_rw, e_pull;
  logic [1:0] e_slot;

  task automatic m_clear();
    e_match = 0; e_gc = 0; e_rw = 0; e_pull = 0; e_slot = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 1; m_phase = 0; m_cnt = 0; m_byte = 0; m_clear();
    end else begin
      bit r, f;
      r = scl && !m_prev;
      f = !scl && m_prev;
      if (stop) begin
        m_phase = 0; m_clear();
      end else if (start) begin
        m_phase = 1; m_cnt = 0; m_byte = 0; m_clear();
      end else if (m_phase == 1 && r) begin
        m_byte = ((m_byte << 1) | int'(sda)) & 255;
        m_cnt++;
        if (m_cnt == 8) begin
          int addr, win;
          addr = m_byte >> 1;
          win = -1;
          for (int s = 3; s >= 0; s--) begin
            bit ok;
            ok = (((addr ^ int'(cfg_a[s] >> 1)) & ~int'(cfg_m[s]) & 127) == 0)
                 || (cfg_a[s][0] && addr == 0);
            if (ok) win = s;
          end
          if (win >= 0 && !master) begin
            e_match = 1; e_slot = 2'(win);
            e_gc = cfg_a[win][0] && addr == 0;
            e_rw = m_byte[0];
            m_phase = 2;
          end else m_phase = 0;
        end
      end else if (m_phase == 2 && f) begin
        e_pull = 1; m_phase = 3;
      end else if (m_phase == 3 && r) begin
        m_phase = 4;
      end else if (m_phase == 4 && f) begin
        e_pull = 0; m_phase = 0;
      end
      m_prev = scl;
    end
  end

  always @(negedge clk) begin
    vectors++;
    if ({match, slot, gcall, rw, pull} !== {e_match, e_slot, e_gc, e_rw, e_pull}) begin
      miscompares++;
      $display("FAIL %s: match/slot/gc/rw/pull act=%b/%0d/%b/%b/%b exp=%b/%0d/%b/%b/%b",
               cur_req, match, slot, gcall, rw, pull, e_match, e_slot, e_gc, e_rw, e_pull);
    end
  end

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_start();
    scl = 1; sda = 0; start = 1; tick(1); start = 0; tick(1);
  endtask

  task automatic do_stop();
    scl = 1; stop = 1; tick(1); stop = 0; sda = 1; tick(2);
  endtask

  task automatic bit_out(logic b);
    scl = 0; tick(1); sda = b; tick(1); scl = 1; tick(2);
  endtask

  task automatic ack_clk();
    scl = 0; sda = 1; tick(2); scl = 1; tick(2); scl = 0; tick(2);
  endtask

  task automatic send_byte(logic [7:0] b);
    do_start();
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic cfg(int k, logic [6:0] a, logic g, logic [6:0] m);
    cfg_a[k] = {a, g}; cfg_m[k] = m;
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin cfg_a[k] = 8'h00; cfg_m[k] = 7'h00; end
    cfg_a[0] = 8'hFE; cfg_a[1] = 8'hFE; cfg_a[2] = 8'hFE; cfg_a[3] = 8'hFE;
    tick(3);
    chk("R1 reset match", match, 0);
    chk("R1 reset pull", pull, 0);
    rst_n = 1; tick(2);
    chk("R1 post-reset match", match, 0);

    // R2 / R8: exact match, read then write
    cur_req = "R2";
    cfg(0, 7'h50, 0, 7'h00);
    send_byte({7'h50, 1'b1});
    chk("R2 match", match, 1); chk("R2 rw", rw, 1);
    cur_req = "R8";
    scl = 0; tick(1);
    chk("R8 pull after low sample", pull, 1);
    tick(1); scl = 1; tick(2); chk("R8 pull held in ninth high", pull, 1);
    scl = 0; tick(1); chk("R8 pull released", pull, 0);
    tick(1);
    cur_req = "R10"; tick(6);
    chk("R10 held slot", slot, 0); chk("R10 held match", match, 1);
    do_stop(); chk("R9 stop clears", match, 0);

    cur_req = "R2";
    send_byte({7'h50, 1'b0}); chk("R2 rw write", rw, 0); ack_clk(); do_stop();

    // R3: masked low nibble
    cur_req = "R3";
    cfg(1, 7'h30, 0, 7'h0F);
    send_byte({7'h3A, 1'b0}); chk("R3 masked hit", match, 1); chk("R3 slot", slot, 1);
    ack_clk(); do_stop();
    send_byte({7'h4A, 1'b0}); chk("R3 unmasked bit differs", match, 0); ack_clk(); do_stop();

    // R5: zero address, no general-call enable
    cur_req = "R5";
    send_byte(8'h00); chk("R5 zero rejected", match, 0);
    ack_clk(); chk("R5 no pull", pull, 0); do_stop();

    // R4: general call via slot 2
    cur_req = "R4";
    cfg(2, 7'h11, 1, 7'h00);
    send_byte(8'h01); chk("R4 gc match", match, 1); chk("R4 gc flag", gcall, 1);
    chk("R4 gc slot", slot, 2); ack_clk(); do_stop();

    // R6: slots 1 and 3 both accept; slot 3 also gc-enabled
    cur_req = "R6";
    cfg(3, 7'h3F, 1, 7'h00);
    send_byte({7'h3F, 1'b1}); chk("R6 lowest slot", slot, 1); chk("R6 no gc", gcall, 0);
    ack_clk(); do_stop();
    cfg(1, 7'h00, 0, 7'h00);
    send_byte(8'h00); chk("R6 ordinary zero on slot1", slot, 1); chk("R6 gc of winner", gcall, 0);
    ack_clk(); do_stop();
    cfg(1, 7'h30, 0, 7'h0F);

    // R7: controller mode
    cur_req = "R7";
    master = 1;
    send_byte({7'h50, 1'b0}); chk("R7 no match", match, 0);
    ack_clk(); chk("R7 no pull", pull, 0); do_stop();
    master = 0;

    // R9: aborts
    cur_req = "R9";
    do_start(); bit_out(1); bit_out(0); bit_out(1);
    do_stop(); bit_out(0); bit_out(0); bit_out(0); bit_out(0); bit_out(0);
    chk("R9 stop aborts byte", match, 0);
    do_start(); bit_out(0); bit_out(1);
    send_byte({7'h50, 1'b1}); chk("R9 restart realigns", match, 1);
    scl = 0; tick(2);
    do_start(); chk("R9 start mid-ack clears", pull, 0);
    for (int i = 7; i >= 0; i--) bit_out(i == 0 ? 1'b0 : 1'b1);
    chk("R9 restart miss", match, 0);
    send_byte({7'h50, 1'b0});
    scl = 1; start = 1; stop = 1; tick(1); start = 0; stop = 0; tick(1);
    for (int i = 7; i >= 0; i--) bit_out(1'b0);
    chk("R9 stop wins over start", match, 0);
    do_stop();

    tick(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule